// File: doc/BRIEF.md
# Seven-Byte Block Register Slave for I2C

This block is a standard-mode I2C target that exposes five 56-bit registers to a bus master. Each register moves as a single seven-byte block, and a command byte selects it. Commands start at 0xE0. Two registers are read-only views of live values supplied by neighbouring logic: a word of configuration readings and a word of measurements. Three registers are writable control words that drive the rest of the converter controller: a control word, a trim word and a threshold word.

The 7-bit bus address is set by three strapping pins. Every transfer carries a length byte that must equal seven. Reads use a repeated start. The block oversamples SCL and SDA with its own system clock. It drives SDA only by pulling it low through an output enable.

Top module: `i2c_blk_slave`

## Requirements
- R1: Reset values. After reset, SDA is released and the control word reads as: bits 39:30 = 1023, bits 29:20 = 1023, bits 19:17 = 3, bits 16:14 = 3, bits 13:5 = 0xFF, all other bits 0. The trim word is 0. The threshold word reads as: bits 39:30 = 40, bits 29:20 = 24, bits 19:10 = 40, bits 9:0 = 24, all other bits 0.
- R2: Address match. The slave acknowledges an address byte only when its upper seven bits equal {4'b0000, addr_sel}. With addr_sel at zero, no address matches. After a mismatch the slave stays off the bus until the next start.
- R3: Command decode. The command byte selects register (command − 0xE0). Commands 0xE0, 0xE1, 0xE3, 0xE4 and 0xE5 are acknowledged. Any other command byte is not acknowledged, and the rest of the transaction is ignored.
- R4: Write length. In a write, the byte after the command is acknowledged only if it equals 7. Any other value aborts the write and leaves all registers unchanged.
- R5: Write data. The seven data bytes arrive least significant byte first, and each byte arrives MSB first. The selected register updates in all 56 bits at once, only after the seventh byte's acknowledge slot ends. A transfer stopped earlier changes nothing.
- R6: Read-only protection. Writes to registers 0 (0xE0) and 1 (0xE1) are acknowledged byte by byte, but they change no register. A later read of register 0 still returns setpt_i.
- R7: Read sequence. The master sends the address with write, the command, a repeated start and the address with read. The slave then returns the length byte 7, followed by the seven register bytes, least significant byte first. It stops driving after a master not-acknowledge.
- R8: Read coherence. A read returns the 56-bit value captured when the address-with-read byte is accepted. Changes to setpt_i or meas_i during the data bytes do not appear in that read.
- R9: Restart. A start condition at any point discards a partial transfer and begins a new address phase. A stop returns the slave to idle and releases SDA.
- R10: Read without command. An address-with-read byte that does not follow an accepted command in the same transaction is not acknowledged.
- R11: Overrun. In a write, any data byte after the seventh is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad (wired level) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 3 | Strapping pins giving the low address bits |
| setpt_i | input | 56 | Live value returned for register 0 |
| meas_i | input | 56 | Live value returned for register 1 |
| ctrl_o | output | 56 | Register 3, control word |
| trim_o | output | 56 | Register 4, trim word |
| thresh_o | output | 56 | Register 5, threshold word |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms start and stop conditions. They also assume that the master never forms a start or stop while the slave is pulling SDA low, and that each SCL phase lasts several system clocks longer than the synchronizer latency. The bench's bit-banged master holds each SCL half-period for 25 clocks. It moves SDA four clocks after SCL falls. It issues stops only after the slave has released the line, so every SDA movement by the slave can be traced to an SCL fall, a start or a stop.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int         BLK_BYTES    = 7;
    localparam int         BLK_W        = BLK_BYTES * 8;
    localparam logic [7:0] CMD_BASE_DEF = 8'hE0;

    localparam logic [2:0] SEL_SETPT  = 3'd0;
    localparam logic [2:0] SEL_MEAS   = 3'd1;
    localparam logic [2:0] SEL_CTRL   = 3'd3;
    localparam logic [2:0] SEL_TRIM   = 3'd4;
    localparam logic [2:0] SEL_THRESH = 3'd5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_LENW,
        PH_WDATA,
        PH_LENR,
        PH_RDATA,
        PH_SKIP
    } phase_e;

    // control word: current limit, voltage limit, two dead-time codes, open-loop duty
    localparam logic [BLK_W-1:0] CTRL_RST =
        {16'd0, 10'd1023, 10'd1023, 3'd3, 3'd3, 9'h0FF, 5'd0};

    // threshold word: input high/low, output high/low
    localparam logic [BLK_W-1:0] THRESH_RST =
        {16'd0, 10'd40, 10'd24, 10'd40, 10'd24};

    function automatic logic sel_writable(input logic [2:0] sel);
        return (sel == SEL_CTRL) || (sel == SEL_TRIM) || (sel == SEL_THRESH);
    endfunction

endpackage

// File: rtl/i2cb_line_sync.sv
module i2cb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_s
);
    localparam int DEPTH = STAGES + 2;
    localparam int NLINE = 2;   // index 1 = SCL, index 0 = SDA

    logic [NLINE-1:0] raw;
    logic [NLINE-1:0] cur;
    logic [NLINE-1:0] prv;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        logic [DEPTH-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[DEPTH-2:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign cur[g] = pipe_q[DEPTH-2];
        assign prv[g] = pipe_q[DEPTH-1];
    end

    assign scl_rise = cur[1] & ~prv[1];
    assign scl_fall = ~cur[1] & prv[1];
    assign start_ev = cur[1] & prv[1] & prv[0] & ~cur[0];
    assign stop_ev  = cur[1] & prv[1] & ~prv[0] & cur[0];
    assign sda_s    = cur[0];

endmodule

// File: rtl/i2cb_cfg_regs.sv
module i2cb_cfg_regs
    import i2cb_pkg::*;
#(
    parameter int               W          = BLK_W,
    parameter logic [W-1:0]     CTRL_INIT  = CTRL_RST,
    parameter logic [W-1:0]     TRIM_INIT  = '0,
    parameter logic [W-1:0]     THR_INIT   = THRESH_RST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   sel,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] setpt_i,
    input  logic [W-1:0] meas_i,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] ctrl_o,
    output logic [W-1:0] trim_o,
    output logic [W-1:0] thresh_o
);
    typedef struct packed {
        logic [W-1:0] thr;
        logic [W-1:0] trim;
        logic [W-1:0] ctrl;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (sel)
                SEL_CTRL:   bank_d.ctrl = wr_data;
                SEL_TRIM:   bank_d.trim = wr_data;
                SEL_THRESH: bank_d.thr  = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '{thr: THR_INIT, trim: TRIM_INIT, ctrl: CTRL_INIT};
        else        bank_q <= bank_d;
    end

    always_comb begin
        case (sel)
            SEL_SETPT:  rd_data = setpt_i;
            SEL_MEAS:   rd_data = meas_i;
            SEL_CTRL:   rd_data = bank_q.ctrl;
            SEL_TRIM:   rd_data = bank_q.trim;
            SEL_THRESH: rd_data = bank_q.thr;
            default:    rd_data = '0;
        endcase
    end

    assign ctrl_o   = bank_q.ctrl;
    assign trim_o   = bank_q.trim;
    assign thresh_o = bank_q.thr;

endmodule

// File: rtl/i2c_blk_slave.sv
module i2c_blk_slave
    import i2cb_pkg::*;
#(
    parameter int         NUM_BYTES   = BLK_BYTES,
    parameter int         ADDR_PINS   = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CMD_BASE    = CMD_BASE_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe,
    input  logic [ADDR_PINS-1:0]     addr_sel,
    input  logic [NUM_BYTES*8-1:0]   setpt_i,
    input  logic [NUM_BYTES*8-1:0]   meas_i,
    output logic [NUM_BYTES*8-1:0]   ctrl_o,
    output logic [NUM_BYTES*8-1:0]   trim_o,
    output logic [NUM_BYTES*8-1:0]   thresh_o
);
    localparam int               REG_W    = NUM_BYTES * 8;
    localparam int               IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BYTES - 1);
    localparam logic [7:0]       LEN_BYTE = 8'(NUM_BYTES);

    typedef struct packed {
        phase_e             phase;
        phase_e             nxt;
        logic [3:0]         bitc;
        logic [7:0]         sh;
        logic [7:0]         tx;
        logic               drv;
        logic               ack;
        logic               mack;
        logic               cmd_ok;
        logic [2:0]         sel;
        logic [IDX_W-1:0]   idx;
        logic               wlast;
        logic               commit;
        logic [REG_W-1:0]   dbuf;
    } st_t;

    st_t d, q;

    logic             scl_rise, scl_fall, start_ev, stop_ev, sda_s;
    logic [REG_W-1:0] rd_data;
    logic             wr_commit;
    logic [2:0]       wr_sel;

    i2cb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_s    (sda_s)
    );

    i2cb_cfg_regs #(.W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_commit),
        .sel      (wr_sel),
        .wr_data  (q.dbuf),
        .setpt_i  (setpt_i),
        .meas_i   (meas_i),
        .rd_data  (rd_data),
        .ctrl_o   (ctrl_o),
        .trim_o   (trim_o),
        .thresh_o (thresh_o)
    );

    logic [7:0] b_in;
    logic [7:0] off;
    logic       addr_hit;
    logic       cmd_valid;
    logic       tx_phase;

    always_comb begin
        d         = q;
        d.commit  = 1'b0;
        b_in      = {q.sh[6:0], sda_s};
        off       = b_in - CMD_BASE;
        addr_hit  = (b_in[7:1] == 7'(addr_sel)) && (addr_sel != '0);
        cmd_valid = (b_in >= CMD_BASE) && (off < 8'd6) && (off != 8'(SEL_MEAS + 3'd1));
        tx_phase  = (q.phase == PH_LENR) || (q.phase == PH_RDATA);

        if (stop_ev) begin
            d.phase  = PH_IDLE;
            d.drv    = 1'b0;
            d.bitc   = '0;
            d.cmd_ok = 1'b0;
            d.wlast  = 1'b0;
        end else if (start_ev) begin
            d.phase  = PH_ADDR;
            d.drv    = 1'b0;
            d.bitc   = '0;
            d.wlast  = 1'b0;
        end else if (q.phase != PH_IDLE && q.phase != PH_SKIP) begin
            if (tx_phase) begin
                if (scl_rise) begin
                    if (q.bitc == 4'd8) begin
                        d.bitc = 4'd9;
                        d.mack = ~sda_s;
                    end else if (q.bitc < 4'd8) begin
                        d.bitc = q.bitc + 4'd1;
                    end
                end else if (scl_fall) begin
                    if (q.bitc < 4'd8) begin
                        d.drv = ~q.tx[7];
                        d.tx  = {q.tx[6:0], 1'b0};
                    end else if (q.bitc == 4'd8) begin
                        d.drv = 1'b0;
                    end else if (q.mack && (q.phase == PH_LENR || q.idx != IDX_LAST)) begin
                        d.phase = PH_RDATA;
                        d.idx   = (q.phase == PH_LENR) ? '0 : q.idx + IDX_W'(1);
                        d.drv   = ~q.dbuf[7];
                        d.tx    = {q.dbuf[6:0], 1'b0};
                        d.dbuf  = q.dbuf >> 8;
                        d.bitc  = '0;
                    end else begin
                        d.phase = PH_SKIP;
                        d.drv   = 1'b0;
                    end
                end
            end else begin
                if (scl_rise) begin
                    if (q.bitc < 4'd7) begin
                        d.sh   = b_in;
                        d.bitc = q.bitc + 4'd1;
                    end else if (q.bitc == 4'd7) begin
                        d.sh   = b_in;
                        d.bitc = 4'd8;
                        d.ack  = 1'b0;
                        d.nxt  = PH_SKIP;
                        case (q.phase)
                            PH_ADDR: begin
                                if (addr_hit && !b_in[0]) begin
                                    d.ack    = 1'b1;
                                    d.nxt    = PH_CMD;
                                    d.cmd_ok = 1'b0;
                                end else if (addr_hit && q.cmd_ok) begin
                                    d.ack  = 1'b1;
                                    d.nxt  = PH_LENR;
                                    d.dbuf = rd_data;
                                end
                            end
                            PH_CMD: begin
                                if (cmd_valid) begin
                                    d.ack    = 1'b1;
                                    d.nxt    = PH_LENW;
                                    d.sel    = off[2:0];
                                    d.cmd_ok = 1'b1;
                                end
                            end
                            PH_LENW: begin
                                if (b_in == LEN_BYTE) begin
                                    d.ack = 1'b1;
                                    d.nxt = PH_WDATA;
                                    d.idx = '0;
                                end
                            end
                            PH_WDATA: begin
                                d.ack  = 1'b1;
                                d.dbuf = {b_in, q.dbuf[REG_W-1:8]};
                                if (q.idx == IDX_LAST) begin
                                    d.wlast = 1'b1;
                                end else begin
                                    d.nxt = PH_WDATA;
                                    d.idx = q.idx + IDX_W'(1);
                                end
                            end
                            default: ;
                        endcase
                    end else if (q.bitc == 4'd8) begin
                        d.bitc = 4'd9;
                    end
                end else if (scl_fall) begin
                    if (q.bitc == 4'd8) begin
                        d.drv = q.ack;
                    end else if (q.bitc == 4'd9) begin
                        d.bitc   = '0;
                        d.phase  = q.nxt;
                        d.drv    = 1'b0;
                        d.commit = q.wlast && sel_writable(q.sel);
                        d.wlast  = 1'b0;
                        if (q.nxt == PH_LENR) begin
                            d.drv = ~LEN_BYTE[7];
                            d.tx  = {LEN_BYTE[6:0], 1'b0};
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.phase  <= PH_IDLE;
            q.nxt    <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.drv;
    assign wr_commit = q.commit;
    assign wr_sel    = q.sel;

endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker #(
    parameter int W = 56
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sda_oe,
    input logic         scl_fall,
    input logic         start_ev,
    input logic         stop_ev,
    input logic         commit,
    input logic [2:0]   wsel,
    input logic [W-1:0] ctrl_o,
    input logic [W-1:0] trim_o,
    input logic [W-1:0] thresh_o
);
    // R1: reset holds the data line released
    a_r1_reset_release: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);

    // R9: a stop always leaves the line released
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R7: the slave moves SDA only after an SCL fall or a bus condition
    a_r7_sda_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

    // R5: writable registers move only on a commit strobe
    a_r5_hold_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ctrl_o) && $stable(trim_o) && $stable(thresh_o)));

    // R5: one commit per completed block
    a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R6: read-only selections never produce a commit
    a_r6_commit_writable: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (wsel == 3'd3 || wsel == 3'd4 || wsel == 3'd5));

endmodule

bind i2c_blk_slave i2cb_checker #(.W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .commit   (wr_commit),
    .wsel     (wr_sel),
    .ctrl_o   (ctrl_o),
    .trim_o   (trim_o),
    .thresh_o (thresh_o)
);

// File: tb/tb_i2c_blk_slave.sv
module tb_i2c_blk_slave;
    localparam int H = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  pins = 3'd3;
    logic [55:0] setpt = 56'h3C_5A69_7788_1122;
    logic [55:0] meas  = 56'h0F_1E2D_3C4B_5A69;
    logic        sda_oe;
    logic [55:0] ctrl, trim, thr;
    wire         sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_blk_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(pins), .setpt_i(setpt), .meas_i(meas),
        .ctrl_o(ctrl), .trim_o(trim), .thresh_o(thr)
    );

    int checks = 0, fails = 0;
    int cyc = 0, settle_until = 0, mism = 0;
    bit done = 1'b0;
    logic [55:0] m3, m4, m5;
    logic [167:0] mm_act, mm_exp;

    // reference model compared every clock against the writable registers
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && !done && cyc >= settle_until) begin
            if ({ctrl, trim, thr} !== {m3, m4, m5}) begin
                if (mism == 0) begin
                    mm_act = {ctrl, trim, thr};
                    mm_exp = {m3, m4, m5};
                end
                mism <= mism + 1;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic hp();
        repeat (H) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    endtask

    task automatic i2c_stop();
        repeat (4) @(negedge clk);
        sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            repeat (4) @(negedge clk);
            sda_m = b[i];
            repeat (H - 4) @(negedge clk);
            scl_m = 1'b1; hp(); scl_m = 1'b0;
        end
        repeat (4) @(negedge clk);
        sda_m = 1'b1;
        repeat (H - 4) @(negedge clk);
        scl_m = 1'b1;
        repeat (H / 2) @(negedge clk);
        ack = !sda_bus;
        repeat (H - H / 2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic rx_byte(input bit ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); scl_m = 1'b1;
            repeat (H / 2) @(negedge clk);
            b[i] = sda_bus;
            repeat (H - H / 2) @(negedge clk);
            scl_m = 1'b0;
        end
        repeat (4) @(negedge clk);
        sda_m = !ack;
        repeat (H - 4) @(negedge clk);
        scl_m = 1'b1; hp(); scl_m = 1'b0;
        repeat (4) @(negedge clk);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] len,
                            input logic [63:0] data, input int nb, output logic [10:0] acks);
        bit k;
        bit will;
        acks = '0;
        will = (a == {4'b0, pins}) && (pins != 3'd0) &&
               (cmd == 8'hE3 || cmd == 8'hE4 || cmd == 8'hE5) && (len == 8'd7) && (nb >= 7);
        i2c_start();
        tx_byte({a, 1'b0}, k); acks[0] = k;
        tx_byte(cmd, k);       acks[1] = k;
        tx_byte(len, k);       acks[2] = k;
        for (int i = 0; i < nb; i++) begin
            tx_byte(data[8*i +: 8], k);
            acks[3+i] = k;
            if (i == 6 && will) begin
                settle_until = cyc + 12;
                if (cmd == 8'hE3) m3 = data[55:0];
                if (cmd == 8'hE4) m4 = data[55:0];
                if (cmd == 8'hE5) m5 = data[55:0];
            end
        end
        i2c_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] cmd, input bit tear,
                           output logic [7:0] lenb, output logic [55:0] d, output logic [2:0] acks);
        bit k;
        logic [7:0] by;
        acks = '0; lenb = '0; d = '0;
        i2c_start();
        tx_byte({a, 1'b0}, k); acks[0] = k;
        tx_byte(cmd, k);       acks[1] = k;
        i2c_start();
        tx_byte({a, 1'b1}, k); acks[2] = k;
        if (k) begin
            rx_byte(1'b1, lenb);
            for (int i = 0; i < 7; i++) begin
                rx_byte(i < 6, by);
                d[8*i +: 8] = by;
                if (tear && i == 1) begin
                    meas  = ~meas;
                    setpt = ~setpt;
                end
            end
        end
        i2c_stop();
    endtask

    logic [55:0] e3, e5, v, old_meas;
    logic [10:0] wa;
    logic [2:0]  ra;
    logic [7:0]  lb;
    logic [55:0] rd;
    bit          k0;

    initial begin
        e3 = '0; e3[39:30] = 10'd1023; e3[29:20] = 10'd1023;
        e3[19:17] = 3'd3; e3[16:14] = 3'd3; e3[13:5] = 9'h0FF;
        e5 = '0; e5[39:30] = 10'd40; e5[29:20] = 10'd24; e5[19:10] = 10'd40; e5[9:0] = 10'd24;
        m3 = e3; m4 = '0; m5 = e5;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1 reset state
        chk("R1 ctrl reset", 64'(ctrl), 64'(e3));
        chk("R1 trim reset", 64'(trim), 64'd0);
        chk("R1 thresh reset", 64'(thr), 64'(e5));
        chk("R1 sda released", 64'(sda_oe), 64'd0);

        // R7 read control word
        do_read(7'h03, 8'hE3, 1'b0, lb, rd, ra);
        chk("R7 read acks", 64'(ra), 64'h7);
        chk("R7 length byte", 64'(lb), 64'd7);
        chk("R7 read data ctrl", 64'(rd), 64'(e3));

        // R5 full write to trim then read back
        v = 56'hA1_B2C3_D4E5_F607;
        do_write(7'h03, 8'hE4, 8'd7, 64'(v), 7, wa);
        chk("R5 write acks", 64'(wa), 64'h3FF);
        chk("R5 trim updated", 64'(trim), 64'(v));
        do_read(7'h03, 8'hE4, 1'b0, lb, rd, ra);
        chk("R5 trim readback", 64'(rd), 64'(v));

        // R5 partial write is discarded
        do_write(7'h03, 8'hE5, 8'd7, 64'h00_1111_2222_3333, 4, wa);
        chk("R5 partial keeps thresh", 64'(thr), 64'(e5));

        // R11 eighth byte refused, first seven committed
        v = 56'h55_6677_8899_AABB;
        do_write(7'h03, 8'hE5, 8'd7, {8'hCC, v}, 8, wa);
        chk("R11 extra byte nack", 64'(wa[10]), 64'd0);
        chk("R11 thresh from seven bytes", 64'(thr), 64'(v));

        // R6 write to read-only register
        do_write(7'h03, 8'hE0, 8'd7, 64'h00_DEAD_BEEF_0123, 7, wa);
        chk("R6 ro write acks", 64'(wa), 64'h3FF);
        chk("R6 outputs unchanged", 64'({ctrl, trim, thr} === {m3, m4, m5}), 64'd1);
        do_read(7'h03, 8'hE0, 1'b0, lb, rd, ra);
        chk("R6 ro read returns live", 64'(rd), 64'(setpt));

        // R3 bad commands
        do_write(7'h03, 8'hE2, 8'd7, 64'h0, 7, wa);
        chk("R3 cmd E2 nack", 64'(wa[1]), 64'd0);
        do_write(7'h03, 8'hE6, 8'd7, 64'h0, 7, wa);
        chk("R3 cmd E6 nack", 64'(wa[1]), 64'd0);
        do_write(7'h03, 8'h55, 8'd7, 64'h0, 7, wa);
        chk("R3 cmd 55 nack", 64'(wa[2:1]), 64'd0);

        // R4 wrong length
        do_write(7'h03, 8'hE3, 8'd6, 64'h00_0000_0000_FFFF, 7, wa);
        chk("R4 length 6 nack", 64'(wa[2:0]), 64'h3);
        chk("R4 ctrl unchanged", 64'(ctrl), 64'(e3));

        // R2 addressing
        do_write(7'h05, 8'hE3, 8'd7, 64'h0, 7, wa);
        chk("R2 wrong address nack", 64'(wa), 64'd0);
        pins = 3'd5;
        do_read(7'h05, 8'hE4, 1'b0, lb, rd, ra);
        chk("R2 new strap acks", 64'(ra), 64'h7);
        chk("R2 new strap data", 64'(rd), 64'(m4));
        pins = 3'd0;
        do_write(7'h00, 8'hE3, 8'd7, 64'h0, 7, wa);
        chk("R2 zero strap nack", 64'(wa[0]), 64'd0);
        pins = 3'd3;

        // R10 read without a command
        i2c_start();
        tx_byte({7'h03, 1'b1}, k0);
        i2c_stop();
        chk("R10 read without cmd nack", 64'(k0), 64'd0);

        // R8 coherent snapshot
        old_meas = meas;
        do_read(7'h03, 8'hE1, 1'b1, lb, rd, ra);
        chk("R8 snapshot meas", 64'(rd), 64'(old_meas));

        // R9 restart mid-write: first transfer discarded, second lands
        i2c_start();
        tx_byte({7'h03, 1'b0}, k0);
        tx_byte(8'hE3, k0);
        tx_byte(8'd7, k0);
        for (int i = 0; i < 3; i++) tx_byte(8'h99, k0);
        v = 56'h12_3456_789A_BCDE;
        do_write(7'h03, 8'hE4, 8'd7, 64'(v), 7, wa);
        chk("R9 restarted write acks", 64'(wa), 64'h3FF);
        chk("R9 aborted ctrl unchanged", 64'(ctrl), 64'(e3));
        chk("R9 trim from second write", 64'(trim), 64'(v));
        chk("R9 sda released after stop", 64'(sda_oe), 64'd0);

        repeat (20) @(negedge clk);
        done = 1'b1;
        chk("R5 R6 per-clock model compare", 64'(mism), 64'd0);
        if (mism != 0) $display("  first mismatch act=%h exp=%h", mm_act, mm_exp);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule